// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Port

This block is the slave end of a three-wire configuration bus. The bus has an active-low select, a serial clock and one shared data line. The port decodes each framed transaction into a register write or a register read. It keeps a bank of 8-bit control registers and presents all of them as a flat vector to the logic they configure. A read is answered on the same data line: the block raises an output enable that steers an external tri-state pad.

All three bus inputs are resynchronised into the local clock domain and edge-detected there, so the serial clock must run several times slower than `clk`. One address is not storage. Writing a magic value to it returns every register to its default value, and reading it returns a status byte. Default values are computed from the register index: register i resets to i XOR `DEF_MASK`, which is 0xA0 by default.

Top module: `tri_wire_cfg_port`

## Requirements
- R1: After a hardware reset, register i (i = 0..NREG-1, i ≠ 0x0A) holds i XOR 0xA0, slot 0x0A of the flat output reads zero, and the data-line output enable is low.
- R2: A frame is 16 serial-clock rising edges while select is low: first a read/write flag (0 = write, 1 = read), then a 7-bit address, then 8 data bits, each field most significant bit first. A write stores the byte in the addressed register at the 16th edge.
- R3: On a read, the output enable stays low through the 8th rising edge. It rises after the falling edge that follows that edge, presenting data bit 7. Each later falling edge presents the next lower bit, so the master collects the byte MSB first on rising edges.
- R4: The output enable drops within a few local clocks once select goes high, and also after the 16th rising edge even if select stays low.
- R5: The output enable is never raised during a write frame.
- R6: A write frame cut short (fewer than 16 rising edges before select rises) changes no register.
- R7: Serial clock and data activity while select is high has no effect, and the next frame decodes from its first bit.
- R8: Writing 0x5A to address 0x0A restores every register to its R1 default. Any other value written there changes nothing.
- R9: Reading address 0x0A returns a status byte: bit 7 is set once a magic-value reset has occurred since hardware reset, and bits 6:0 hold NREG (16 by default).
- R10: Writes to addresses at or above NREG are ignored, and reads from them return 0x00.
- R11: Rising edges beyond the 16th within one select-low period are ignored. They cause neither a second write nor any further driving of the data line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Bus select, active low |
| sclk | input | 1 | Bus serial clock |
| sdio_in | input | 1 | Data line as seen at the pad input |
| sdio_out | output | 1 | Read data to drive onto the data line |
| sdio_oe | output | 1 | Enable for the data-line output driver |
| cfg_regs | output | NREG*8 | All control registers, register i in bits [8i+7:8i] |

## Verification
The embedded properties hold on every cycle. They check that the output enable drops after select rises, that it is never raised on a write frame, and that it first rises only on a falling edge right after the 8th rising edge. They also check that the register bank changes only at a completed 16th write edge and that the bit counter never passes 16. Only the bench scenarios can show whole-frame behaviour: the byte value read back, the discarding of short and oversized frames, the magic-value reset against a wrong value at the same address, the status byte contents, and silence toward unimplemented addresses. A behavioural model of the register bank is compared with the flat output on every quiet clock.

// File: rtl/tri_wire_cfg_port.sv
module tri_wire_cfg_port #(
  parameter int NREG = 16,
  parameter int DW = 8,
  parameter int AW = 7,
  parameter int SPECIAL_ADDR = 10,
  parameter logic [DW-1:0] MAGIC = 8'h5A,
  parameter logic [DW-1:0] DEF_MASK = 8'hA0,
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdio_in,
  output logic sdio_out,
  output logic sdio_oe,
  output logic [NREG*DW-1:0] cfg_regs
);
  localparam int FRAME = 1 + AW + DW;
  localparam int CW = $clog2(FRAME + 1);
  localparam int IW = $clog2(NREG);
  localparam logic [CW-1:0] CTL_LAST = CW'(AW);
  localparam logic [CW-1:0] DAT_FIRST = CW'(AW + 1);
  localparam logic [CW-1:0] LAST = CW'(FRAME - 1);
  localparam logic [CW-1:0] FULL = CW'(FRAME);
  localparam logic [AW-1:0] SPA = AW'(SPECIAL_ADDR);

  function automatic logic [NREG*DW-1:0] defaults();
    logic [NREG*DW-1:0] v;
    for (int i = 0; i < NREG; i++)
      v[i*DW +: DW] = (i == SPECIAL_ADDR) ? '0 : (DW'(i) ^ DEF_MASK);
    return v;
  endfunction

  function automatic logic implemented(input logic [AW-1:0] a);
    return (int'(a) < NREG) && (a != SPA);
  endfunction

  logic [SYNC-1:0] cs_q, ck_q, di_q;
  logic cs_s, ck_s, di_s, ck_d;
  logic [CW-1:0] cnt;
  logic [FRAME-2:0] sh;
  logic rw_q, rd_mode, srst_seen;
  logic [AW-1:0] a_q;
  logic [DW-1:0] rd_sh, rd_val;
  logic [NREG*DW-1:0] cfg_q;

  assign cs_s = cs_q[SYNC-1];
  assign ck_s = ck_q[SYNC-1];
  assign di_s = di_q[SYNC-1];
  assign cfg_regs = cfg_q;

  wire rise = !cs_s && ck_s && !ck_d;
  wire fall = !cs_s && !ck_s && ck_d;
  wire [AW-1:0] ctl_addr = {sh[AW-2:0], di_s};
  wire [DW-1:0] wr_data = {sh[DW-2:0], di_s};
  wire frame_end = rise && (cnt == LAST) && !rw_q;

  always_comb begin
    if (ctl_addr == SPA) rd_val = {srst_seen, (DW-1)'(NREG)};
    else if (implemented(ctl_addr)) rd_val = cfg_q[IW'(ctl_addr)*DW +: DW];
    else rd_val = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q <= '1;
      ck_q <= '0;
      di_q <= '0;
      ck_d <= 1'b0;
    end else begin
      cs_q <= {cs_q[SYNC-2:0], cs_n};
      ck_q <= {ck_q[SYNC-2:0], sclk};
      di_q <= {di_q[SYNC-2:0], sdio_in};
      ck_d <= ck_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      sh <= '0;
      rw_q <= 1'b0;
      a_q <= '0;
      rd_mode <= 1'b0;
      rd_sh <= '0;
      sdio_out <= 1'b0;
      sdio_oe <= 1'b0;
      srst_seen <= 1'b0;
      cfg_q <= defaults();
    end else if (cs_s) begin
      cnt <= '0;
      rd_mode <= 1'b0;
      sdio_oe <= 1'b0;
    end else begin
      if (rise && cnt < FULL) begin
        cnt <= cnt + 1'b1;
        sh <= {sh[FRAME-3:0], di_s};
        if (cnt == CTL_LAST) begin
          rw_q <= sh[AW-1];
          rd_mode <= sh[AW-1];
          a_q <= ctl_addr;
          rd_sh <= rd_val;
        end
        if (cnt == LAST) begin
          rd_mode <= 1'b0;
          sdio_oe <= 1'b0;
          if (!rw_q) begin
            if (a_q == SPA && wr_data == MAGIC) begin
              cfg_q <= defaults();
              srst_seen <= 1'b1;
            end else if (implemented(a_q)) begin
              cfg_q[IW'(a_q)*DW +: DW] <= wr_data;
            end
          end
        end
      end
      if (fall && rd_mode && cnt >= DAT_FIRST) begin
        sdio_oe <= 1'b1;
        sdio_out <= rd_sh[DW-1];
        rd_sh <= {rd_sh[DW-2:0], 1'b0};
      end
    end
  end

  a_r4_release_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !sdio_oe);
  a_r5_quiet_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> rw_q);
  a_r3_turnaround_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdio_oe) |-> ($past(fall) && $past(cnt) == DAT_FIRST));
  a_r6_bank_changes_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(cfg_q));
  a_r11_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);
endmodule

// File: tb/test_tri_wire_cfg_port.sv
module test_tri_wire_cfg_port;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 6;
  localparam int NREG = 16;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdio_in = 1'b0;
  logic sdio_out, sdio_oe;
  logic [NREG*8-1:0] cfg_regs;

  int checks = 0, fails = 0;
  bit quiet = 1'b0, done = 1'b0;
  logic [7:0] model [NREG];
  bit srst_model = 1'b0;

  tri_wire_cfg_port #(.NREG(NREG)) i_tri_wire_cfg_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .cfg_regs(cfg_regs));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] dflt(int i);
    return (i == 10) ? 8'h00 : (8'(i) ^ 8'hA0);
  endfunction

  function automatic logic [NREG*8-1:0] model_flat();
    logic [NREG*8-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (quiet && !done) check("R2 model compare", cfg_regs, model_flat());

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input bit rw, input logic [6:0] a, input logic [7:0] d,
                      input int nbits, output logic [7:0] rd, output bit oe_bad);
    logic [15:0] fr;
    fr = {rw, a, d};
    rd = '0;
    oe_bad = 1'b0;
    quiet = 1'b0;
    @(negedge clk);
    cs_n = 1'b0;
    idle(HP);
    for (int i = 0; i < nbits; i++) begin
      sdio_in = (i < 16) ? fr[15-i] : 1'b1;
      if (rw && i >= 8) sdio_in = 1'b0;
      idle(HP);
      if (rw && i >= 8 && i < 16) begin
        if (sdio_oe !== 1'b1) oe_bad = 1'b1;
        rd = {rd[6:0], sdio_out};
      end else if (sdio_oe !== 1'b0) oe_bad = 1'b1;
      sclk = 1'b1;
      idle(HP);
      sclk = 1'b0;
    end
    idle(HP);
    if (nbits >= 16 && sdio_oe !== 1'b0) oe_bad = 1'b1;
    cs_n = 1'b1;
    idle(HP);
    if (sdio_oe !== 1'b0) oe_bad = 1'b1;
    idle(HP);
  endtask

  task automatic wr(logic [6:0] a, logic [7:0] d, int nbits);
    logic [7:0] r;
    bit bad;
    xfer(1'b0, a, d, nbits, r, bad);
    check("R5 no drive on write", bad, 1'b0);
    if (nbits >= 16) begin
      if (a == 7'h0A) begin
        if (d == 8'h5A) begin
          for (int i = 0; i < NREG; i++) model[i] = dflt(i);
          srst_model = 1'b1;
        end
      end else if (int'(a) < NREG) model[a] = d;
    end
    quiet = 1'b1;
    idle(2);
  endtask

  task automatic rdchk(string req, logic [6:0] a, logic [7:0] exp);
    logic [7:0] r;
    bit bad;
    xfer(1'b1, a, 8'h00, 16, r, bad);
    check({req, " read data"}, r, exp);
    check("R3 R4 enable timing", bad, 1'b0);
    quiet = 1'b1;
    idle(2);
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = dflt(i);
    idle(4);
    rst_n = 1'b1;
    idle(4);
    check("R1 reset bank", cfg_regs, model_flat());
    check("R1 reset enable", sdio_oe, 1'b0);
    quiet = 1'b1;

    wr(7'h03, 8'h3C, 16);
    check("R2 write stored", cfg_regs[3*8 +: 8], 8'h3C);
    rdchk("R2 R3", 7'h03, 8'h3C);
    wr(7'h00, 8'hFF, 16);
    wr(7'h0F, 8'h81, 16);
    wr(7'h07, 8'h00, 16);
    rdchk("R3", 7'h00, 8'hFF);
    rdchk("R3", 7'h0F, 8'h81);
    rdchk("R3 default", 7'h05, 8'hA5);

    begin
      logic [7:0] r;
      bit bad;
      wr(7'h01, 8'h44, 12);
      wr(7'h01, 8'h45, 15);
      check("R6 short write dropped", cfg_regs[1*8 +: 8], 8'hA1);
      xfer(1'b1, 7'h00, 8'h00, 12, r, bad);
      check("R4 release on deselect", sdio_oe, 1'b0);
      quiet = 1'b1;
    end

    for (int k = 0; k < 20; k++) begin
      sdio_in = k[0] ^ k[2];
      sclk = ~sclk;
      idle(HP);
    end
    sclk = 1'b0;
    idle(HP);
    check("R7 ignored while deselected", cfg_regs, model_flat());
    rdchk("R7 next frame", 7'h0F, 8'h81);

    wr(7'h0A, 8'h33, 16);
    check("R8 wrong value no reset", cfg_regs[0 +: 8], 8'hFF);
    rdchk("R9 status before", 7'h0A, 8'h10);
    wr(7'h0A, 8'h5A, 16);
    check("R8 soft reset", cfg_regs[0 +: 8], 8'hA0);
    check("R8 soft reset bank", cfg_regs, model_flat());
    rdchk("R9 status after", 7'h0A, 8'h90);

    wr(7'h40, 8'h77, 16);
    wr(7'h10, 8'h66, 16);
    check("R10 unimplemented write", cfg_regs, model_flat());
    rdchk("R10", 7'h40, 8'h00);
    rdchk("R10", 7'h10, 8'h00);

    wr(7'h02, 8'h5C, 24);
    check("R11 extra clocks ignored", cfg_regs[2*8 +: 8], 8'h5C);
    rdchk("R11", 7'h02, 8'h5C);

    quiet = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule